// File: doc/BRIEF.md
# Transfer ID Tracker

This block keeps two counters for one DMA channel so that software can tell exactly which transfers have finished. The launch path pulses an issue strobe each time a transfer is accepted; that transfer takes the ID currently on the next-ID output, and the counter then moves on by one. The backend pulses a retire strobe each time a transfer finishes, which moves the completed-ID output on by one. A transfer with ID k has finished when the completed ID is at least k.

The status path reads the next ID, the completed ID and a busy flag. Busy is high while any issued transfer has not retired. Busy is found by comparing the two counters at their own width, so it stays correct when the counters wrap. Each channel needs its own copy of this block, so one channel can be busy while another issues and retires transfers.

Top module: `xfer_id_tracker`

## Requirements
- R1: After a synchronous active-low reset, next_id_o is 1, done_id_o is 0 and busy_o is 0, so no transfer can read as finished before it is issued.
- R2: A cycle with issue_i high raises next_id_o by one, modulo 2^ID_W, starting from the clock edge that samples the strobe.
- R3: A cycle with retire_i high raises done_id_o by one, modulo 2^ID_W, starting from the clock edge that samples the strobe.
- R4: busy_o is 1 exactly when the number of issues and the number of retires differ modulo 2^ID_W. This is tested as next_id_o being different from done_id_o + 1. A retire while busy_o is 0 is illegal input.
- R5: If issue_i and retire_i are high in the same cycle, both counters advance in that cycle and neither event is lost.
- R6: A transfer given ID k reads as unfinished (done_id_o < k) until its retire strobe is taken, and reads as finished (done_id_o >= k) from then on, as long as the counters have not wrapped.
- R7: In a cycle with neither strobe high, next_id_o and done_id_o keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| issue_i | input | 1 | One-cycle pulse: a launch was accepted |
| retire_i | input | 1 | One-cycle pulse: the backend finished a transfer |
| next_id_o | output | ID_W | ID that the next launch will receive |
| done_id_o | output | ID_W | ID of the most recently completed transfer |
| busy_o | output | 1 | At least one issued transfer has not retired |

## Verification
Both counters drive their outputs directly from registers. A missed or doubled strobe therefore shows on next_id_o or done_id_o one cycle after the strobe edge, and it stays wrong from then on, because nothing ever resynchronises the counters. An error in the busy comparison shows at the next idle or full point: busy_o stays high after the last retire, or drops while a transfer is still outstanding. The bench uses a 4-bit ID and drives long mixed strobe sequences through several wraps and up to 15 outstanding transfers. It compares all three outputs after every cycle.

// File: rtl/xid_pkg.sv
// Shared types for the transfer ID tracker.
// Assumes: strobes are single-cycle and synchronous to the tracker clock.
package xid_pkg;

    // Default counter width for an ID.
    localparam int unsigned XID_DEF_W = 32;

    // The two per-cycle events the tracker counts.
    typedef struct packed {
        logic issue;
        logic retire;
    } xid_evt_t;

endpackage

// File: rtl/xid_wrap_ctr.sv
// Wrapping up-counter with a reset value set by a parameter.
// It counts one event per enabled cycle and wraps modulo 2^W.
// Assumes: en is a one-cycle strobe; rst_n is synchronous and active low.
module xid_wrap_ctr #(
    parameter int unsigned     W       = 32,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    output logic [W-1:0] q
);

    localparam logic [W-1:0] STEP = W'(1);

    // Load the reset value, or add one on each enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else if (en) begin
            q <= q + STEP;
        end
    end

endmodule

// File: rtl/xid_busy_cmp.sv
// Works out whether a channel has outstanding transfers.
// The next ID is always (issued count + 1) and the completed ID is always
// the retired count, so the channel is idle exactly when next == done + 1.
// The comparison is done at width W, so it stays correct across a wrap.
// Assumes: fewer than 2^W transfers are outstanding at any time.
module xid_busy_cmp #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] nxt,
    input  logic [W-1:0] done,
    output logic         busy
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] done_plus;

    // Busy whenever issues and retires differ modulo 2^W.
    always_comb begin
        done_plus = done + ONE;
        busy      = (nxt != done_plus);
    end

endmodule

// File: rtl/xfer_id_tracker.sv
// Transfer ID tracker for a single DMA channel.
// The issue counter starts at 1 and holds the ID that the next launch will get.
// The retire counter starts at 0 and holds the last completed ID.
// Busy compares the two counters at the same width.
// Assumes: one-cycle strobes, no retire while idle, and fewer than 2^ID_W
// transfers outstanding.
module xfer_id_tracker #(
    parameter int unsigned ID_W = xid_pkg::XID_DEF_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_i,
    input  logic            retire_i,
    output logic [ID_W-1:0] next_id_o,
    output logic [ID_W-1:0] done_id_o,
    output logic            busy_o
);

    typedef logic [ID_W-1:0] id_t;
    localparam id_t FIRST_ID = ID_W'(1);
    localparam id_t NONE_DONE = '0;

    xid_pkg::xid_evt_t ev;

    // Pack the strobes into one event record.
    always_comb begin
        ev.issue  = issue_i;
        ev.retire = retire_i;
    end

    xid_wrap_ctr #(.W(ID_W), .RST_VAL(FIRST_ID)) u_issue_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ev.issue),
        .q     (next_id_o)
    );

    xid_wrap_ctr #(.W(ID_W), .RST_VAL(NONE_DONE)) u_retire_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ev.retire),
        .q     (done_id_o)
    );

    xid_busy_cmp #(.W(ID_W)) u_busy (
        .nxt  (next_id_o),
        .done (done_id_o),
        .busy (busy_o)
    );

    // R2: an issue moves the next ID on by exactly one.
    a_r2_next_step: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i |=> next_id_o == id_t'($past(next_id_o) + FIRST_ID));

    // R3: a retire moves the completed ID on by exactly one.
    a_r3_done_step: assert property (@(posedge clk) disable iff (!rst_n)
        retire_i |=> done_id_o == id_t'($past(done_id_o) + FIRST_ID));

    // R5: both strobes in one cycle update both counters.
    a_r5_both_step: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && retire_i) |=> (next_id_o != $past(next_id_o)) && (done_id_o != $past(done_id_o)));

    // R7: with no strobe, both counters hold their values.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!issue_i && !retire_i) |=> $stable(next_id_o) && $stable(done_id_o));

    // R4: a retire while nothing is outstanding is illegal.
    a_r4_retire_legal: assert property (@(posedge clk) disable iff (!rst_n)
        retire_i |-> busy_o);

endmodule

// File: tb/sim_xfer_id_tracker.sv
// Bench: 4-bit IDs, long mixed strobe sequences with several wraps.
// The expected values come from a simple modulo-16 model kept in the bench.
module sim_xfer_id_tracker;

    localparam int W = 4;
    localparam int MOD = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic issue_i = 1'b0;
    logic retire_i = 1'b0;
    logic [W-1:0] next_id_o, done_id_o;
    logic busy_o;

    int checks = 0;
    int bad = 0;
    int exp_next = 1;
    int exp_done = 0;
    int outst = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    xfer_id_tracker #(.ID_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .retire_i(retire_i),
        .next_id_o(next_id_o), .done_id_o(done_id_o), .busy_o(busy_o)
    );

    // Compare one value and report a mismatch.
    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Run one cycle with the given strobes, update the model, and check all outputs.
    task automatic cyc(input bit iss, input bit ret, input string req);
        issue_i  = iss;
        retire_i = ret;
        @(posedge clk);
        #2;
        issue_i  = 1'b0;
        retire_i = 1'b0;
        if (iss) begin exp_next = (exp_next + 1) % MOD; outst++; end
        if (ret) begin exp_done = (exp_done + 1) % MOD; outst--; end
        chk({req, " next"}, int'(next_id_o), exp_next);
        chk({req, " done"}, int'(done_id_o), exp_done);
        chk({req, " R4 busy"}, int'(busy_o), (outst != 0) ? 1 : 0);
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #2000000;
        if (!finished) begin
            bad++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        int id_a;
        repeat (3) @(negedge clk);
        // R1: values held in reset.
        chk("R1 next", int'(next_id_o), 1);
        chk("R1 done", int'(done_id_o), 0);
        chk("R1 busy", int'(busy_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 next after release", int'(next_id_o), 1);
        // R7: idle cycles hold both counters.
        cyc(0, 0, "R7");
        cyc(0, 0, "R7");
        // R6: a transfer reads as finished only after it retires.
        id_a = int'(next_id_o);
        cyc(1, 0, "R2");
        chk("R6 not finished", (int'(done_id_o) >= id_a) ? 1 : 0, 0);
        cyc(1, 0, "R2");
        cyc(0, 1, "R3");
        chk("R6 finished", (int'(done_id_o) >= id_a) ? 1 : 0, 1);
        chk("R6 next not finished", (int'(done_id_o) >= id_a + 1) ? 1 : 0, 0);
        // R5: both strobes in the same cycle.
        cyc(1, 1, "R5");
        cyc(0, 1, "R3");
        // Fill to 15 outstanding (busy across a wrap), then drain.
        for (int k = 0; k < 15; k++) cyc(1, 0, "R2 fill");
        cyc(1, 1, "R5 full");
        for (int k = 0; k < 15; k++) cyc(0, 1, "R3 drain");
        chk("R4 idle after drain", int'(busy_o), 0);
        // Long mixed sweep through all strobe combinations.
        for (int n = 0; n < 600; n++) begin
            bit iss = ((n * 7) % 3) != 0;
            bit ret = ((n * 5) % 4) < 2;
            if (outst >= 15) iss = 1'b0;
            if (outst == 0) ret = 1'b0;
            cyc(iss, ret, "R5 sweep");
        end
        while (outst > 0) cyc(0, 1, "R3 final drain");
        cyc(0, 0, "R7 final");
        chk("R4 final idle", int'(busy_o), 0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule